// File: doc/BRIEF.md
# SAR ADC Host Acquisition Controller

This block is the system-side master for a 16-bit successive-approximation converter that has a four-wire synchronous serial port. A request carries a channel number, a single-ended/differential flag, a two-bit power mode and a framing choice. The controller drives chip select, the serial clock and the command line, samples the converter's data and busy lines, and returns a 16-bit straight-binary result with a one-cycle valid strobe.

The serial clock comes from the system clock: each phase lasts a fixed number of system clocks, and a further parameter sets the delay from chip select falling to the first clock. A frame uses either 24 or 32 serial clocks. In 24-clock framing, a request that is already waiting when the 24th clock ends is started at once, without releasing chip select. Its start bit then shares the serial clock that reads the previous result's least significant bit.

Top module: `sar_acq_host`

## Requirements
- R1: During and after reset, cs_n is high, dclk is low, din is low, res_valid is low and req_ready is high.
- R2: The command byte goes out MSB first, one bit per serial clock on clocks 1 to 8. Bit 7 is a start bit of 1. Bits 6:4 hold the channel code (channel 0 = 001, 1 = 101, 2 = 010, 3 = 110). Bit 3 is 0. Bit 2 is req_single (1 = single-ended, 0 = differential). Bits 1:0 are req_pd. din changes only when dclk falls, so it is stable for the whole high phase.
- R3: Each high phase and each low phase of dclk lasts exactly DIV_HALF system clocks.
- R4: The first rising dclk edge of a frame comes CS_SETUP + DIV_HALF system clocks after cs_n falls. dclk stays low whenever cs_n is high.
- R5: busy is sampled on the rising edge of clock 9. dout is sampled on the rising edges of clocks 10 to 25. The first sample becomes result bit 15 and the last becomes bit 0.
- R6: In 24-clock framing with no request waiting, the frame runs 25 clocks with din low on the 25th. cs_n rises together with the 25th falling edge.
- R7: In 24-clock framing, a request waiting at the falling edge of clock 24 is accepted there. cs_n stays low, and the next clock carries the new start bit while it captures the previous result's LSB.
- R8: In 32-clock framing, the frame runs 32 clocks. The value on dout during clocks 26 to 32 has no effect on the result. cs_n rises with the 32nd falling edge.
- R9: res_valid is high for exactly one system clock per result, in the cycle after the LSB is sampled.
- R10: A frame in which busy is not high at the clock-9 sample gives no res_valid pulse.
- R11: req_ready is high only when the controller is idle, or at the falling edge of clock 24 of a 24-clock frame. A request held at any other time is not taken.
- R12: din is low on every clock after the 8th, except where it carries a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Request taken on this clock when valid |
| req_chan | input | 2 | Channel number 0 to 3 |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_pd | input | 2 | Power mode bits sent in the command |
| req_long | input | 1 | 1 = 32-clock framing, 0 = 24-clock framing |
| cs_n | output | 1 | Converter chip select, active low |
| dclk | output | 1 | Serial clock |
| din | output | 1 | Command bit to the converter |
| dout | input | 1 | Serial data from the converter |
| busy | input | 1 | Busy flag from the converter |
| res_data | output | 16 | Conversion result, straight binary |
| res_valid | output | 1 | One-cycle strobe for res_data |

## Verification
A clock index that is off by one moves the whole result one bit to the side, or swaps the busy slot for a data bit. A word with distinct upper and lower halves shows this in the very first result. A wrong overlap decision shows up within one frame: cs_n releases where it should not, the serial clock count of the chip-select window changes, or the second frame's command byte arrives garbled. A stuck phase counter shows up in the measured phase widths on the first serial clock.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;
  localparam int IDX_W     = 5;
  localparam int CTL_BITS  = 8;
  localparam int DATA_BITS = 16;
  typedef logic [IDX_W-1:0] idx_t;
  // Clock indices count from 0 at the start-bit clock.
  localparam idx_t BUSY_IDX   = idx_t'(CTL_BITS);
  localparam idx_t DATA_FIRST = idx_t'(CTL_BITS + 1);
  localparam idx_t DATA_LAST  = idx_t'(CTL_BITS + DATA_BITS);
  localparam idx_t SHORT_END  = idx_t'(CTL_BITS + DATA_BITS - 1);
  localparam idx_t LONG_END   = idx_t'(4 * CTL_BITS - 1);
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH} seq_st_t;
endpackage

// File: rtl/sar_cmd_pack.sv
module sar_cmd_pack
  import sar_host_pkg::*;
(
  input  logic [1:0]          chan_i,
  input  logic                single_i,
  input  logic [1:0]          pd_i,
  output logic [CTL_BITS-1:0] byte_o
);
  logic [2:0] code;

  always_comb begin
    case (chan_i)
      2'd0:    code = 3'b001;
      2'd1:    code = 3'b101;
      2'd2:    code = 3'b010;
      default: code = 3'b110;
    endcase
    byte_o = {1'b1, code, 1'b0, single_i, pd_i};
  end
endmodule

// File: rtl/sar_rx_shift.sv
module sar_rx_shift
  import sar_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy_en,
  input  logic                 shift_en,
  input  logic                 final_en,
  input  logic                 dout_i,
  input  logic                 busy_i,
  output logic [DATA_BITS-1:0] res_data_o,
  output logic                 res_valid_o
);
  logic [DATA_BITS-1:0] sr_q, sr_d, res_q, res_d;
  logic                 bok_q, bok_d, val_q, val_d;

  always_comb begin
    sr_d  = sr_q;
    res_d = res_q;
    bok_d = bok_q;
    val_d = 1'b0;
    if (busy_en)  bok_d = busy_i;
    if (shift_en) sr_d  = {sr_q[DATA_BITS-2:0], dout_i};
    if (final_en) begin
      res_d = {sr_q[DATA_BITS-2:0], dout_i};
      val_d = bok_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      res_q <= '0;
      bok_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      res_q <= res_d;
      bok_q <= bok_d;
      val_q <= val_d;
    end
  end

  assign res_data_o  = res_q;
  assign res_valid_o = val_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_host_pkg::*;
#(
  parameter int DIV_HALF = 52,
  parameter int CS_SETUP = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic                req_long_i,
  input  logic [CTL_BITS-1:0] ctl_byte_i,
  output logic                req_ready_o,
  output logic                cs_n_o,
  output logic                dclk_o,
  output logic                din_o,
  output logic                busy_en_o,
  output logic                shift_en_o,
  output logic                final_en_o
);
  localparam int CNT_MAX = (DIV_HALF > CS_SETUP) ? DIV_HALF : CS_SETUP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(DIV_HALF - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(CS_SETUP - 1);

  seq_st_t             st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  idx_t                idx_q, idx_d, last_idx;
  logic [CTL_BITS-1:0] ctl_q, ctl_d;
  logic                long_q, long_d, tail_q, tail_d;
  logic                cs_n_q, cs_n_d, dclk_q, dclk_d, din_q, din_d;
  logic                rise_now, fall_now, cnt_zero, take;

  assign cnt_zero    = (cnt_q == '0);
  assign rise_now    = (st_q == ST_LOW)  && cnt_zero;
  assign fall_now    = (st_q == ST_HIGH) && cnt_zero;
  assign last_idx    = long_q ? LONG_END : DATA_LAST;
  assign req_ready_o = (st_q == ST_IDLE) ||
                       (fall_now && !long_q && (idx_q == SHORT_END));
  assign take        = req_valid_i && req_ready_o;
  assign busy_en_o   = rise_now && (idx_q == BUSY_IDX);
  assign shift_en_o  = rise_now && (idx_q >= DATA_FIRST) && (idx_q < DATA_LAST);
  assign final_en_o  = rise_now && ((idx_q == DATA_LAST) || (tail_q && (idx_q == '0)));

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; ctl_d = ctl_q;
    long_d = long_q; tail_d = tail_q;
    cs_n_d = cs_n_q; dclk_d = dclk_q; din_d = din_q;
    case (st_q)
      ST_IDLE: if (take) begin
        st_d = ST_SETUP; cs_n_d = 1'b0; cnt_d = SETUP_LD;
        idx_d = '0; tail_d = 1'b0; long_d = req_long_i;
        ctl_d = ctl_byte_i; din_d = ctl_byte_i[CTL_BITS-1];
      end
      ST_SETUP: if (cnt_zero) begin
        st_d = ST_LOW; cnt_d = HALF_LD;
      end else cnt_d = cnt_q - 1'b1;
      ST_LOW: if (cnt_zero) begin
        st_d = ST_HIGH; dclk_d = 1'b1; cnt_d = HALF_LD;
        if (final_en_o) tail_d = 1'b0;
      end else cnt_d = cnt_q - 1'b1;
      default: if (cnt_zero) begin
        dclk_d = 1'b0;
        if (idx_q == last_idx) begin
          st_d = ST_IDLE; cs_n_d = 1'b1; din_d = 1'b0;
        end else if (take) begin
          st_d = ST_LOW; cnt_d = HALF_LD; idx_d = '0; tail_d = 1'b1;
          long_d = req_long_i; ctl_d = ctl_byte_i;
          din_d = ctl_byte_i[CTL_BITS-1];
        end else begin
          st_d = ST_LOW; cnt_d = HALF_LD; idx_d = idx_q + 1'b1;
          din_d = ctl_q[CTL_BITS-2];
          ctl_d = {ctl_q[CTL_BITS-2:0], 1'b0};
        end
      end else cnt_d = cnt_q - 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; ctl_q <= '0;
      long_q <= 1'b0; tail_q <= 1'b0;
      cs_n_q <= 1'b1; dclk_q <= 1'b0; din_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; ctl_q <= ctl_d;
      long_q <= long_d; tail_q <= tail_d;
      cs_n_q <= cs_n_d; dclk_q <= dclk_d; din_q <= din_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign dclk_o = dclk_q;
  assign din_o  = din_q;
endmodule

// File: rtl/sar_acq_host.sv
module sar_acq_host
  import sar_host_pkg::*;
#(
  parameter int DIV_HALF = 52,
  parameter int CS_SETUP = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_chan,
  input  logic        req_single,
  input  logic [1:0]  req_pd,
  input  logic        req_long,
  output logic        cs_n,
  output logic        dclk,
  output logic        din,
  input  logic        dout,
  input  logic        busy,
  output logic [15:0] res_data,
  output logic        res_valid
);
  logic [1:0]          rst_pipe_q;
  logic                rst_sync_n;
  logic [CTL_BITS-1:0] ctl_byte;
  logic                busy_en, shift_en, final_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sar_cmd_pack u_pack (
    .chan_i(req_chan), .single_i(req_single), .pd_i(req_pd), .byte_o(ctl_byte)
  );

  sar_seq #(.DIV_HALF(DIV_HALF), .CS_SETUP(CS_SETUP)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .req_valid_i(req_valid), .req_long_i(req_long),
    .ctl_byte_i(ctl_byte), .req_ready_o(req_ready), .cs_n_o(cs_n), .dclk_o(dclk),
    .din_o(din), .busy_en_o(busy_en), .shift_en_o(shift_en), .final_en_o(final_en)
  );

  sar_rx_shift u_rx (
    .clk(clk), .rst_n(rst_sync_n), .busy_en(busy_en), .shift_en(shift_en),
    .final_en(final_en), .dout_i(dout), .busy_i(busy),
    .res_data_o(res_data), .res_valid_o(res_valid)
  );
endmodule

// File: rtl/sar_acq_host_chk.sv
module sar_acq_host_chk #(
  parameter int DIV_HALF = 52
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic cs_n,
  input logic dclk,
  input logic din,
  input logic res_valid
);
  int unsigned hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= dclk ? ((hi_run < 32'hFFFF) ? hi_run + 1 : hi_run) : 0;
      lo_run <= !dclk ? ((lo_run < 32'hFFFF) ? lo_run + 1 : lo_run) : 0;
    end
  end

  // R3
  dclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk) |-> (hi_run >= DIV_HALF));
  // R3
  dclk_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> (lo_run >= DIV_HALF));
  // R4
  dclk_quiet_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dclk);
  // R2
  din_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk && $past(dclk)) |-> $stable(din));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R11
  accept_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !cs_n);
  // R6
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!dclk && !din));
endmodule

bind sar_acq_host sar_acq_host_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cs_n(cs_n), .dclk(dclk), .din(din), .res_valid(res_valid)
);

// File: tb/sar_acq_host_tb.sv
module sar_acq_host_tb;
  localparam int DIV   = 4;
  localparam int SETUP = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, req_single = 1'b0, req_long = 1'b0;
  logic [1:0] req_chan = '0, req_pd = '0;
  logic req_ready, cs_n, dclk, din, res_valid;
  logic dout = 1'b0, busy = 1'b0;
  logic [15:0] res_data;

  sar_acq_host #(.DIV_HALF(DIV), .CS_SETUP(SETUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_single(req_single), .req_pd(req_pd), .req_long(req_long),
    .cs_n(cs_n), .dclk(dclk), .din(din), .dout(dout), .busy(busy),
    .res_data(res_data), .res_valid(res_valid)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  int k = 0, fidx = -1, din_err = 0, clocks_win = 0, clocks_last = 0, cs_rises = 0;
  logic [15:0] wtab [0:15];
  logic [7:0]  ctl_got [0:15];
  bit          busy_off [0:15];

  always @(posedge dclk) begin
    if (cs_n === 1'b0) begin
      clocks_win++;
      if ((k == 0 || k >= 24) && din === 1'b1 && fidx < 15) begin
        k = 1; fidx++; ctl_got[fidx] = 8'h80;
      end else if (k != 0) begin
        k++;
        if (k <= 8) ctl_got[fidx][8-k] = din;
        else if (din !== 1'b0) din_err++;
      end
    end
  end

  always @(negedge dclk) begin
    if (cs_n === 1'b0 && k != 0 && fidx >= 0) begin
      if (k == 8) busy = !busy_off[fidx];
      else if (k == 9) begin busy = 1'b0; dout = wtab[fidx][15]; end
      else if (k >= 10 && k <= 24) dout = wtab[fidx][24-k];
      else if (k >= 25) dout = 1'b1;
      else dout = 1'b0;
    end
  end

  always @(posedge cs_n) begin
    clocks_last = clocks_win; clocks_win = 0; k = 0; cs_rises++;
  end

  // result and timing monitors
  int ngot = 0, vrun = 0, vmax = 0;
  logic [15:0] got [0:15];
  int hcnt = 0, lcnt = 0, hmin = 99999, hmax = 0, lmin = 99999, lmax = 0, setup_w = -1;
  bit seen_fall = 0;

  always @(negedge clk) begin
    if (res_valid === 1'b1) begin
      if (ngot < 16) got[ngot] = res_data;
      ngot++; vrun++;
      if (vrun > vmax) vmax = vrun;
    end else vrun = 0;
    if (rst_n) begin
      if (dclk) hcnt++;
      else if (hcnt > 0) begin
        if (hcnt < hmin) hmin = hcnt;
        if (hcnt > hmax) hmax = hcnt;
        hcnt = 0; seen_fall = 1;
      end
      if (cs_n) begin lcnt = 0; seen_fall = 0; end
      else if (!dclk) lcnt++;
      else if (lcnt > 0) begin
        if (seen_fall) begin
          if (lcnt < lmin) lmin = lcnt;
          if (lcnt > lmax) lmax = lcnt;
        end else setup_w = lcnt;
        lcnt = 0;
      end
    end
  end

  function automatic logic [7:0] exp_ctl(input logic [1:0] ch, input logic sgl, input logic [1:0] pd);
    logic [2:0] c;
    c = (ch == 2'd0) ? 3'b001 : (ch == 2'd1) ? 3'b101 : (ch == 2'd2) ? 3'b010 : 3'b110;
    return {1'b1, c, 1'b0, sgl, pd};
  endfunction

  task automatic send(input logic [1:0] ch, input logic sgl, input logic [1:0] pd, input logic lng);
    @(negedge clk);
    req_chan = ch; req_single = sgl; req_pd = pd; req_long = lng; req_valid = 1'b1;
    while (req_ready !== 1'b1) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_release(input int target);
    int n = 0;
    while (cs_rises < target && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && dclk === 1'b0 && din === 1'b0, "R1 pins in reset", {cs_n, dclk, din}, 3'b100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(res_valid === 1'b0 && req_ready === 1'b1 && cs_n === 1'b1, "R1 idle after reset",
        {res_valid, req_ready, cs_n}, 3'b011);
    cs_rises = 0; clocks_last = 0;
  endtask

  task automatic t_single24;
    wtab[0] = 16'hA5C3; busy_off[0] = 0;
    send(2'd1, 1'b1, 2'b11, 1'b0);
    wait_release(1);
    chk(ctl_got[0] == exp_ctl(2'd1, 1'b1, 2'b11), "R2 command byte ch1", ctl_got[0], exp_ctl(2'd1, 1'b1, 2'b11));
    chk(ngot == 1 && got[0] == 16'hA5C3, "R5 result msb first", got[0], 16'hA5C3);
    chk(clocks_last == 25, "R6 clocks without pending request", clocks_last, 25);
    chk(din_err == 0, "R12 din low after byte", din_err, 0);
  endtask

  task automatic t_long32;
    int bad = 0;
    wtab[1] = 16'h8001; busy_off[1] = 0;
    send(2'd2, 1'b0, 2'b10, 1'b1);
    @(negedge clk); req_valid = 1'b1; req_chan = 2'd3;
    for (int i = 0; i < 40; i++) begin
      if (req_ready !== 1'b0) bad++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(bad == 0, "R11 no accept mid frame", bad, 0);
    wait_release(2);
    chk(fidx == 1, "R11 held request not taken", fidx, 1);
    chk(ctl_got[1] == exp_ctl(2'd2, 1'b0, 2'b10), "R2 command byte ch2 diff", ctl_got[1], exp_ctl(2'd2, 1'b0, 2'b10));
    chk(clocks_last == 32, "R8 clocks in long frame", clocks_last, 32);
    chk(ngot == 2 && got[1] == 16'h8001, "R8 trailing ones ignored", got[1], 16'h8001);
  endtask

  task automatic t_overlap;
    wtab[2] = 16'h1234; wtab[3] = 16'hFFFE; busy_off[2] = 0; busy_off[3] = 0;
    send(2'd3, 1'b1, 2'b00, 1'b0);
    send(2'd0, 1'b0, 2'b01, 1'b0);
    wait_release(3);
    chk(clocks_last == 49, "R7 one select window for two frames", clocks_last, 49);
    chk(cs_rises == 3, "R7 cs held low across overlap", cs_rises, 3);
    chk(ngot == 4 && got[2] == 16'h1234, "R7 lsb captured on start clock", got[2], 16'h1234);
    chk(got[3] == 16'hFFFE, "R5 second overlapped result", got[3], 16'hFFFE);
    chk(ctl_got[2] == exp_ctl(2'd3, 1'b1, 2'b00), "R2 command byte ch3", ctl_got[2], exp_ctl(2'd3, 1'b1, 2'b00));
    chk(ctl_got[3] == exp_ctl(2'd0, 1'b0, 2'b01), "R7 overlapped command byte", ctl_got[3], exp_ctl(2'd0, 1'b0, 2'b01));
    chk(din_err == 0, "R12 din low after overlapped bytes", din_err, 0);
  endtask

  task automatic t_nobusy;
    wtab[4] = 16'h0F0F; busy_off[4] = 1;
    wtab[5] = 16'h7FFF; busy_off[5] = 0;
    send(2'd0, 1'b1, 2'b11, 1'b0);
    wait_release(4);
    chk(ngot == 4, "R10 no strobe without busy slot", ngot, 4);
    send(2'd1, 1'b1, 2'b11, 1'b0);
    wait_release(5);
    chk(ngot == 5 && got[4] == 16'h7FFF, "R10 next frame recovers", got[4], 16'h7FFF);
  endtask

  task automatic t_timing;
    chk(hmin == DIV && hmax == DIV, "R3 high phase width", hmax, DIV);
    chk(lmin == DIV && lmax == DIV, "R3 low phase width", lmax, DIV);
    chk(setup_w == SETUP + DIV, "R4 select to first rise", setup_w, SETUP + DIV);
    chk(vmax == 1, "R9 single cycle strobe", vmax, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin wtab[i] = '0; ctl_got[i] = '0; busy_off[i] = 0; end
    t_reset;
    t_single24;
    t_long32;
    t_overlap;
    t_nobusy;
    t_timing;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule